// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a one-shot alarm that counts whole seconds down to zero. Software loads a number of seconds, then sets the run bit. Each one-second tick pulse arriving while the alarm runs takes one off the remaining count. When the count steps from one to zero, a sticky pending flag is set.

The pending flag is gated onto two separate outputs. One is an interrupt line and the other is a wake-up line, and each has its own enable bit. Software clears the flag by writing a one to it.

Registers are reached through a plain single-cycle register port. Writes take effect at the clock edge on which the write strobe is high. Read data is a combinational decode of the address, so there is no handshake and no back-pressure. The tick input is a one-cycle pulse in the same clock domain. The safe programming order is:
1. Stop the alarm.
2. Clear the pending flag.
3. Load zero.
4. Load the new count.
5. Start the alarm.

Register word addresses on `addr_i`:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | LOAD | read/write | 32-bit count of seconds to load |
| 1 | REMAIN | read-only | Current remaining count |
| 2 | RUN | read/write | Bit 0 runs the countdown |
| 3 | IRQ_EN | read/write | Bit 0 is the interrupt enable |
| 4 | STAT | read, write 1 to clear | Bit 0 is the pending flag |
| 5 | WAKE_EN | read/write | Bit 0 is the wake-up enable |

Top module: `sca_alarm`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wake_o` are low.
- R2: A write to LOAD (address 0) stores the value, which then reads back from LOAD. The value is also copied into the remaining count, which reads back from REMAIN (address 1) after that same clock edge. A load write overrides a tick in the same cycle, so no decrement happens.
- R3: While RUN bit 0 (address 2) is 1, each cycle with `tick_i` high and a nonzero count lowers the remaining count by exactly one. Cycles without a tick leave it unchanged.
- R4: While RUN bit 0 is 0, ticks do not change the remaining count.
- R5: A tick that takes the count from 1 to 0 while running sets the pending flag, STAT bit 0 (address 4). The count then stays at 0.
- R6: A count of 0 that is running produces no pending event, however many ticks arrive.
- R7: Writing STAT with bit 0 = 1 clears the pending flag, and writing bit 0 = 0 leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R8: A set pending flag stays set when RUN is cleared, and stays set until it is cleared by a write.
- R9: `irq_o` is high exactly when the pending flag and IRQ_EN bit 0 (address 3) are both 1.
- R10: `wake_o` is high exactly when the pending flag and WAKE_EN bit 0 (address 5) are both 1.
- R11: Writes to REMAIN are ignored; the remaining count is not changed.
- R12: The single-bit registers (RUN, IRQ_EN, STAT, WAKE_EN) keep only bit 0, and all their other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt output |
| wake_o | output | 1 | Wake-up output |

## Verification
The hardest situations to reach from the ports are collisions in a single cycle. In one, the tick that would make the count expire coincides with a write that clears the pending flag. In the other, a load write coincides with a tick. Directed steps drive the write strobe and the tick in the same cycle to cover both. Random phases keep the loaded counts small, so that expiries, reloads and run toggles overlap often, and check against a cycle model derived from the requirements.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_REMAIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_WAKEEN = 3'd5;
endpackage

// File: rtl/sca_counter.sv
module sca_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] count_o,
  output logic          fire_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q;
  logic          step;

  // A tick only counts while running, with no load pending, above zero
  assign step   = run_i && tick_i && !load_i && (cnt_q != '0);
  assign fire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - ONE;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sca_regs.sv
module sca_regs
  import sca_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              fire_i,
  input  logic [DW-1:0]     count_i,
  output logic [DW-1:0]     rdata_o,
  output logic              load_o,
  output logic              run_o,
  output logic              irq_en_o,
  output logic              wake_en_o,
  output logic              pend_o
);
  logic [DW-1:0] load_q;
  logic run_q, irq_en_q, wake_en_q, pend_q;
  logic clr;

  assign load_o = wr_en_i && (addr_i == A_LOAD);
  assign clr    = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= '0;
      run_q     <= 1'b0;
      irq_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_LOAD:   load_q    <= wdata_i;
        A_RUN:    run_q     <= wdata_i[0];
        A_IRQEN:  irq_en_q  <= wdata_i[0];
        A_WAKEEN: wake_en_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  // Sticky flag: an expiry outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (fire_i) pend_q <= 1'b1;
    else if (clr)    pend_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD:   rdata_o = load_q;
      A_REMAIN: rdata_o = count_i;
      A_RUN:    rdata_o[0] = run_q;
      A_IRQEN:  rdata_o[0] = irq_en_q;
      A_STAT:   rdata_o[0] = pend_q;
      A_WAKEEN: rdata_o[0] = wake_en_q;
      default:  rdata_o = '0;
    endcase
  end

  assign run_o     = run_q;
  assign irq_en_o  = irq_en_q;
  assign wake_en_o = wake_en_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/sca_alarm.sv
module sca_alarm
  import sca_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [DW-1:0] cnt_w;
  logic load_w, run_w, irq_en_w, wake_en_w, pend_w, fire_w;

  sca_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .fire_i    (fire_w),
    .count_i   (cnt_w),
    .rdata_o   (rdata_o),
    .load_o    (load_w),
    .run_o     (run_w),
    .irq_en_o  (irq_en_w),
    .wake_en_o (wake_en_w),
    .pend_o    (pend_w)
  );

  sca_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (run_w),
    .load_i     (load_w),
    .load_val_i (wdata_i),
    .count_o    (cnt_w),
    .fire_o     (fire_w)
  );

  assign irq_o  = pend_w && irq_en_w;
  assign wake_o = pend_w && wake_en_w;
endmodule

// File: rtl/sca_alarm_chk.sv
module sca_alarm_chk
  import sca_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              run,
  input logic [DW-1:0]     cnt,
  input logic              pend,
  input logic              irq_o,
  input logic              wake_o
);
  logic ld, clr;
  assign ld  = wr_en_i && (addr_i == A_LOAD);
  assign clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> cnt == $past(wdata_i));
  a_r3_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !ld && cnt != '0) |=> cnt == $past(cnt) - DW'(1));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !ld) |=> cnt == $past(cnt));
  a_r5_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !ld && cnt == DW'(1)) |=> pend);
  a_r6_fire_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> ($past(cnt) == DW'(1) && $past(tick_i) && $past(run)));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !clr) |=> pend);
  a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend);
  a_r10_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> pend);
endmodule

bind sca_alarm sca_alarm_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .run     (run_w),
  .cnt     (cnt_w),
  .pend    (pend_w),
  .irq_o   (irq_o),
  .wake_o  (wake_o)
);

// File: tb/sca_alarm_tb.sv
module sca_alarm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq, wake;
  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // bench model state
  logic [DW-1:0] m_load = '0, m_cnt = '0;
  logic m_run = 0, m_ie = 0, m_we = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sca_alarm #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  // One clock cycle with optional write and tick; model follows the requirements
  task automatic step(bit w, logic [2:0] a, logic [DW-1:0] d, bit t);
    logic fire;
    wr = w; addr = a; wdata = d; tick = t;
    fire = 0;
    @(posedge clk); #1;
    wr = 0; tick = 0;
    if (w && a == 3'd0) m_cnt = d;
    else if (m_run && t && m_cnt != 0) begin
      fire = (m_cnt == 1);
      m_cnt = m_cnt - 1;
    end
    if (w) case (a)
      3'd0: m_load = d;
      3'd2: m_run = d[0];
      3'd3: m_ie = d[0];
      3'd5: m_we = d[0];
      default: ;
    endcase
    if (fire) m_pend = 1;
    else if (w && a == 3'd4 && d[0]) m_pend = 0;
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] v;
    rd(3'd0, v); chk({tag, " LOAD"}, v, m_load);
    rd(3'd1, v); chk({tag, " REMAIN"}, v, m_cnt);
    rd(3'd2, v); chk({tag, " RUN"}, v, {31'd0, m_run});
    rd(3'd4, v); chk({tag, " STAT"}, v, {31'd0, m_pend});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_pend & m_ie});
    chk({tag, " wake"}, {31'd0, wake}, {31'd0, m_pend & m_we});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > WDOG) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <%0d", cycles, WDOG);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R1 reset reg", v, '0);
    end
    chk("R1 irq", {31'd0, irq}, '0);
    chk("R1 wake", {31'd0, wake}, '0);

    // R2 load and readback
    step(1, 3'd0, 32'hDEADBEEF, 0);
    rd(3'd1, v); chk("R2 remain after load", v, 32'hDEADBEEF);
    check_all("R2");
    // R11 write to REMAIN ignored
    step(1, 3'd1, 32'h5, 0);
    rd(3'd1, v); chk("R11 remain unchanged", v, 32'hDEADBEEF);
    // R12 upper bits dropped
    step(1, 3'd2, 32'hFFFF_FFFE, 0);
    rd(3'd2, v); chk("R12 run bit0 only", v, 32'd0);
    step(1, 3'd3, 32'hFFFF_FFFF, 0);
    rd(3'd3, v); chk("R12 irq_en reads 1", v, 32'd1);
    step(1, 3'd3, 32'd0, 0);

    // R4 disabled ticks do nothing
    step(1, 3'd0, 32'd3, 0);
    step(0, 3'd0, 0, 1); step(0, 3'd0, 0, 1);
    rd(3'd1, v); chk("R4 no decrement while stopped", v, 32'd3);

    // R3 countdown, R5 fire, R9/R10 gating
    step(1, 3'd3, 32'd1, 0);
    step(1, 3'd2, 32'd1, 0);
    step(0, 3'd0, 0, 0);
    rd(3'd1, v); chk("R3 no tick no change", v, 32'd3);
    step(0, 3'd0, 0, 1);
    rd(3'd1, v); chk("R3 decrement by one", v, 32'd2);
    step(0, 3'd0, 0, 1);
    chk("R5 not yet pending", {31'd0, irq}, '0);
    step(0, 3'd0, 0, 1);
    rd(3'd4, v); chk("R5 pending on 1->0", v, 32'd1);
    chk("R9 irq with enable", {31'd0, irq}, 32'd1);
    chk("R10 wake gated off", {31'd0, wake}, 32'd0);
    step(1, 3'd5, 32'd1, 0);
    chk("R10 wake on", {31'd0, wake}, 32'd1);
    step(0, 3'd0, 0, 1);
    rd(3'd1, v); chk("R5 stays at zero", v, 32'd0);
    // R8 persists after disable
    step(1, 3'd2, 32'd0, 0);
    rd(3'd4, v); chk("R8 pending held", v, 32'd1);
    // R7 write 0 no effect, write 1 clears
    step(1, 3'd4, 32'd0, 0);
    rd(3'd4, v); chk("R7 write 0 keeps", v, 32'd1);
    step(1, 3'd4, 32'd1, 0);
    rd(3'd4, v); chk("R7 W1C clears", v, 32'd0);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R6 zero loaded, running, no event
    step(1, 3'd0, 32'd0, 0);
    step(1, 3'd2, 32'd1, 0);
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 1);
    rd(3'd4, v); chk("R6 no fire from zero", v, 32'd0);

    // R2 load beats tick in same cycle
    step(1, 3'd0, 32'd7, 1);
    rd(3'd1, v); chk("R2 load wins over tick", v, 32'd7);

    // R7 set beats simultaneous clear
    step(1, 3'd0, 32'd1, 0);
    step(1, 3'd4, 32'd1, 1);
    rd(3'd4, v); chk("R7 set wins over clear", v, 32'd1);
    check_all("R7 collision");

    // Random mix, small counts
    for (int i = 0; i < 1500; i++) begin
      int unsigned r = $urandom % 10;
      bit t = ($urandom % 2) == 1;
      logic [2:0] a = 3'($urandom % 6);
      logic [DW-1:0] d = (a == 3'd0) ? DW'($urandom % 5) : DW'($urandom);
      if (r < 3) step(1, a, d, t);
      else step(0, 3'd0, 0, t);
      if (i % 5 == 0) check_all("random R3 R5 R7 R9 R10");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule